// File: doc/BRIEF.md
# Planar Video Pixel Serializer

This block sits between the plane fetch stage and the colour lookup stage of a display pipeline. Each fetch delivers one byte from each of four video memory planes, all read at the same address. The block turns those four bytes into a stream of pixel indices, one per clock.

Two mode bits choose how the planes are interleaved. Planar mode gives 16 colours: each pixel takes one bit from every plane. Packed mode uses 2 bits per pixel and pairs the planes. The 256-colour mode outputs each plane byte whole. The mode also sets how many pixels one fetch yields.

A ready output tells the fetch stage when the next group of bytes can be taken. Its timing lets the next group start on the clock after the last pixel of the current group, so the stream has no gap.

Top module: `planar_pixel_serializer`

## Requirements
- R1: After reset, `pixValid` is 0 and `fetchReady` is 1.
- R2: When `wide256` is 1, the 256-colour mode is used whatever `packedSel` holds. When `wide256` is 0, `packedSel`=1 selects packed mode and `packedSel`=0 selects planar mode.
- R3: Planar mode yields 8 pixels per fetch. Pixel i (i=0..7) has bit k (k=0..3) equal to bit 7-i of plane k.
- R4: Packed mode yields 8 pixels per fetch. For pixel i with i=0..3, bits [1:0] equal plane 0 bits [7-2i:6-2i], and bits [3:2] equal plane 2 bits [7-2i:6-2i].
- R5: In packed mode, pixel 4+j (j=0..3) takes bits [1:0] from plane 1 bits [7-2j:6-2j] and bits [3:2] from plane 3 bits [7-2j:6-2j].
- R6: The 256-colour mode yields 4 pixels per fetch. Pixel n equals the byte of plane n, where plane n sits on `planeBytes[8n+7:8n]`.
- R7: In planar and packed modes, bits [7:4] of `pixIdx` are 0.
- R8: `fetchReady` is 1 while the block is idle and during the last pixel of a group, and 0 on every other valid pixel. A load that arrives while `fetchReady` is 1 is accepted, and its first pixel is valid on the next clock. This means back-to-back groups stream with no idle cycle.
- R9: A load that arrives while `fetchReady` is 0 is ignored. The current group continues unchanged, and no extra pixels are produced.
- R10: The mode is sampled when a load is accepted. Changing `wide256` or `packedSel` during a group has no effect on that group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loadStb | input | 1 | Offers a new group of plane bytes |
| planeBytes | input | 32 | Plane n byte on bits [8n+7:8n] |
| wide256 | input | 1 | Selects the 256-colour mode |
| packedSel | input | 1 | Selects packed mode when `wide256` is 0 |
| pixIdx | output | 8 | Pixel index |
| pixValid | output | 1 | `pixIdx` holds a pixel |
| fetchReady | output | 1 | A load is accepted on this clock |

## Verification
The bench compares every pixel in all three modes against values it computes itself, with the plane bytes chosen so that each bit position can be told apart. It sets both mode bits at once to catch a priority decode that wrongly favours packed mode. It also checks that packed mode reads plane 1 and plane 3 in the second half of a group: a design that shifted all four planes together would output zeros or stale bits there.

Back-to-back bursts that mix group lengths expose a one-cycle bubble or a ready flag that comes a pixel late. A load sent while the block is busy, and a mode change sent while it is busy, expose a design that restarts or re-decodes in the middle of a group. Either fault shows up as extra or corrupted pixels.

// File: rtl/pxser_pkg.sv
package pxser_pkg;
  localparam int NUM_PLANES = 4;

  typedef enum logic [1:0] {
    MODE_PLANAR = 2'd0,
    MODE_PACKED = 2'd1,
    MODE_WIDE   = 2'd2
  } shiftMode_t;

  typedef struct packed {
    logic       load;
    logic       shift;
    shiftMode_t mode;
    logic [2:0] slot;
  } ctrlStrb_t;
endpackage

// File: rtl/pxser_ctrl.sv
module pxser_ctrl
  import pxser_pkg::*;
#(
  parameter int PLANE_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      loadStb,
  input  logic      wide256,
  input  logic      packedSel,
  output ctrlStrb_t strb,
  output logic      pixValid,
  output logic      fetchReady
);
  localparam int CNT_W = $clog2(PLANE_W);
  localparam logic [CNT_W-1:0] LAST_BITWISE = CNT_W'(PLANE_W - 1);
  localparam logic [CNT_W-1:0] LAST_WIDE    = CNT_W'(NUM_PLANES - 1);

  logic             active;
  logic [CNT_W-1:0] cnt;
  shiftMode_t       modeQ;
  shiftMode_t       modeReq;
  logic [CNT_W-1:0] lastIdx;
  logic             lastPix;
  logic             accept;

  always_comb begin
    if (wide256)        modeReq = MODE_WIDE;
    else if (packedSel) modeReq = MODE_PACKED;
    else                modeReq = MODE_PLANAR;
  end

  assign lastIdx    = (modeQ == MODE_WIDE) ? LAST_WIDE : LAST_BITWISE;
  assign lastPix    = active && (cnt == lastIdx);
  assign fetchReady = !active || lastPix;
  assign accept     = loadStb && fetchReady;
  assign pixValid   = active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      cnt    <= '0;
      modeQ  <= MODE_PLANAR;
    end else if (accept) begin
      active <= 1'b1;
      cnt    <= '0;
      modeQ  <= modeReq;
    end else if (lastPix) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (active) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    strb       = '0;
    strb.load  = accept;
    strb.shift = active && !accept;
    strb.mode  = modeQ;
    strb.slot  = 3'(cnt);
  end

  // R8
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |-> fetchReady);
  // R8
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && fetchReady) |=> pixValid);
  // R9
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !fetchReady) |=> (pixValid && cnt == $past(cnt) + 1'b1));
  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && !accept && !lastPix) |=> $stable(modeQ));
  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && modeQ == MODE_WIDE) |-> (cnt <= LAST_WIDE));
endmodule

// File: rtl/pxser_dpath.sv
module pxser_dpath
  import pxser_pkg::*;
#(
  parameter int PLANE_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrb_t                     strb,
  input  logic [NUM_PLANES*PLANE_W-1:0] planeBytes,
  input  logic                          pixValid,
  output logic [PLANE_W-1:0]            pixIdx
);
  localparam int PAD_W = PLANE_W - NUM_PLANES;

  logic [PLANE_W-1:0] planeQ [NUM_PLANES];
  logic               upperHalf;

  assign upperHalf = strb.slot[2];

  for (genvar g = 0; g < NUM_PLANES; g++) begin : g_plane
    localparam logic ODD_PLANE = logic'(g % 2);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        planeQ[g] <= '0;
      end else if (strb.load) begin
        planeQ[g] <= planeBytes[g*PLANE_W +: PLANE_W];
      end else if (strb.shift) begin
        case (strb.mode)
          MODE_PLANAR: planeQ[g] <= planeQ[g] << 1;
          MODE_PACKED: if (ODD_PLANE == upperHalf) planeQ[g] <= planeQ[g] << 2;
          default:     planeQ[g] <= planeQ[g];
        endcase
      end
    end
  end

  always_comb begin
    pixIdx = '0;
    case (strb.mode)
      MODE_PLANAR: begin
        for (int k = 0; k < NUM_PLANES; k++) pixIdx[k] = planeQ[k][PLANE_W-1];
      end
      MODE_PACKED: begin
        if (upperHalf)
          pixIdx = {{PAD_W{1'b0}}, planeQ[3][PLANE_W-1 -: 2], planeQ[1][PLANE_W-1 -: 2]};
        else
          pixIdx = {{PAD_W{1'b0}}, planeQ[2][PLANE_W-1 -: 2], planeQ[0][PLANE_W-1 -: 2]};
      end
      default: pixIdx = planeQ[strb.slot[1:0]];
    endcase
  end

  // R7
  narrow_modes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && strb.mode != MODE_WIDE) |-> (pixIdx[PLANE_W-1:NUM_PLANES] == '0));
  // R6
  wide_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shift && strb.mode == MODE_WIDE) |=> $stable(planeQ[0]));
endmodule

// File: rtl/planar_pixel_serializer.sv
module planar_pixel_serializer
  import pxser_pkg::*;
#(
  parameter int PLANE_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          loadStb,
  input  logic [NUM_PLANES*PLANE_W-1:0] planeBytes,
  input  logic                          wide256,
  input  logic                          packedSel,
  output logic [PLANE_W-1:0]            pixIdx,
  output logic                          pixValid,
  output logic                          fetchReady
);
  ctrlStrb_t strb;

  pxser_ctrl #(.PLANE_W(PLANE_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .wide256(wide256),
    .packedSel(packedSel), .strb(strb), .pixValid(pixValid),
    .fetchReady(fetchReady)
  );

  pxser_dpath #(.PLANE_W(PLANE_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .planeBytes(planeBytes),
    .pixValid(pixValid), .pixIdx(pixIdx)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk) $rose(rstN) |-> (!pixValid && fetchReady));
endmodule

// File: tb/test_planar_pixel_serializer.sv
module test_planar_pixel_serializer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadStb = 1'b0;
  logic [31:0] planeBytes = '0;
  logic        wide256 = 1'b0;
  logic        packedSel = 1'b0;
  logic [7:0]  pixIdx;
  logic        pixValid;
  logic        fetchReady;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit prevValid = 1'b0;

  logic [7:0] expPix[$];
  logic       expLast[$];
  logic       expNarrow[$];
  string      expTag[$];

  always #10 clk = ~clk;

  planar_pixel_serializer i_planar_pixel_serializer (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .planeBytes(planeBytes),
    .wide256(wide256), .packedSel(packedSel), .pixIdx(pixIdx),
    .pixValid(pixValid), .fetchReady(fetchReady)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // mode: 0 planar, 1 packed, 2 wide
  task automatic pushExpected(input logic [31:0] b, input int mode, input string tag);
    logic [7:0] p [4];
    int n;
    for (int k = 0; k < 4; k++) p[k] = b[8*k +: 8];
    n = (mode == 2) ? 4 : 8;
    for (int i = 0; i < n; i++) begin
      logic [7:0] v;
      v = '0;
      if (mode == 0) begin
        for (int k = 0; k < 4; k++) v[k] = p[k][7-i];
      end else if (mode == 1) begin
        if (i < 4) v = {4'b0, p[2][7-2*i -: 2], p[0][7-2*i -: 2]};
        else       v = {4'b0, p[3][7-2*(i-4) -: 2], p[1][7-2*(i-4) -: 2]};
      end else begin
        v = p[i];
      end
      expPix.push_back(v);
      expLast.push_back(i == n - 1);
      expNarrow.push_back(mode != 2);
      expTag.push_back(tag);
    end
  endtask

  task automatic sendGroup(input logic [31:0] b, input bit w, input bit pk,
                           input int mode, input string tag);
    while (!fetchReady) @(negedge clk);
    loadStb    = 1'b1;
    planeBytes = b;
    wide256    = w;
    packedSel  = pk;
    pushExpected(b, mode, tag);
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      if (pixValid) begin
        if (expPix.size() == 0) begin
          check(1'b0, "R9 unexpected pixel", pixIdx, 0);
        end else begin
          logic [7:0] e;
          logic       l;
          logic       nr;
          string      t;
          e = expPix.pop_front();
          l = expLast.pop_front();
          nr = expNarrow.pop_front();
          t = expTag.pop_front();
          check(pixIdx == e, t, pixIdx, e);
          check(fetchReady == l, "R8 ready timing", fetchReady, l);
          if (nr) check(pixIdx[7:4] == 4'h0, "R7 upper bits", pixIdx[7:4], 0);
        end
      end else if (prevValid && expPix.size() != 0) begin
        check(1'b0, "R8 gap in stream", 0, 1);
      end
      prevValid = pixValid;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(pixValid == 1'b0, "R1 valid at reset", pixValid, 0);
    check(fetchReady == 1'b1, "R1 ready at reset", fetchReady, 1);
    rstN = 1'b1;
    @(negedge clk);
    check(pixValid == 1'b0 && fetchReady == 1'b1, "R1 idle after reset",
          {pixValid, fetchReady}, 1);

    // R3 planar patterns
    sendGroup(32'h01_80_FF_00, 0, 0, 0, "R3 planar");
    sendGroup(32'hA5_3C_0F_F0, 0, 0, 0, "R3 planar");
    // R4 R5 packed
    sendGroup(32'hE4_1B_4E_B1, 0, 1, 1, "R4 R5 packed");
    sendGroup(32'h00_FF_00_FF, 0, 1, 1, "R4 R5 packed");
    // R6 wide
    sendGroup(32'hDE_AD_BE_EF, 1, 0, 2, "R6 wide");
    // R2 priority: both bits set
    sendGroup(32'h12_34_56_78, 1, 1, 2, "R2 priority");
    repeat (12) @(negedge clk);

    // R8 back-to-back mixed burst, starting from idle
    sendGroup(32'h81_42_24_18, 0, 0, 0, "R8 burst");
    sendGroup(32'hC3_99_66_3C, 1, 0, 2, "R8 burst");
    sendGroup(32'h55_AA_33_CC, 0, 1, 1, "R8 burst");
    sendGroup(32'h01_02_03_04, 1, 1, 2, "R8 burst");
    sendGroup(32'h7E_E7_5A_A5, 0, 0, 0, "R8 burst");
    repeat (12) @(negedge clk);

    // R9 load while busy is ignored
    sendGroup(32'h0F_F0_3C_C3, 0, 0, 0, "R9 busy load");
    @(negedge clk);
    check(fetchReady == 1'b0, "R9 busy", fetchReady, 0);
    loadStb = 1'b1; planeBytes = 32'hFFFF_FFFF; wide256 = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
    repeat (12) @(negedge clk);

    // R10 mode change during group
    sendGroup(32'h9C_63_F0_0F, 0, 1, 1, "R10 mode held");
    wide256 = 1'b1; packedSel = 1'b0;
    repeat (3) @(negedge clk);
    wide256 = 1'b0; packedSel = 1'b0;
    repeat (12) @(negedge clk);
    sendGroup(32'h11_22_44_88, 0, 0, 0, "R10 next group");
    repeat (12) @(negedge clk);

    check(expPix.size() == 0, "R8 all pixels delivered", expPix.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule